// File: doc/BRIEF.md
# Receive Idle Timeout Detector

This block watches a serial receiver's incoming byte stream and the fill state of its receive queue. It raises an interrupt when bytes have been sitting unread while the line stayed quiet. Time is measured in bit-time ticks, which come from the receiver's baud generator as single-cycle pulses. Software programs a 24-bit tick count and sets an enable. When the count expires, software learns that a partial block is waiting. It does not have to wait for a watermark that may never be reached.

The idle count runs only while the queue holds data and nothing happens on it. A new byte arriving, a byte being read, or the queue draining each restart the count from zero. Once the count reaches the programmed value, the interrupt is set and stays set until a clear pulse. The counter then parks at the programmed value, so one idle period produces one interrupt. A new idle period cannot begin until some restart condition occurs.

Top module: `rx_idle_timeout`

## Requirements
- R1: After a synchronous reset, `irq_o` is 0 and the idle count is zero.
- R2: With the queue non-empty, the detector enabled, a non-zero limit N and no byte or pop strobes, `irq_o` is still 0 after N-1 ticks. It reads 1 on the cycle after the clock edge that samples the N-th tick. For N = 1 the first tick sets it.
- R3: While `fifo_nonempty_i` is 0 the count is held at zero and no number of ticks sets `irq_o`. A single empty cycle in the middle of a count restarts it.
- R4: A `byte_rcvd_i` pulse restarts the count. After such a pulse, a full N further ticks are needed to set `irq_o`.
- R5: A `fifo_pop_i` pulse restarts the count. After such a pulse, a full N further ticks are needed to set `irq_o`.
- R6: Once set, `irq_o` stays at 1 whatever the queue, strobe, enable and tick inputs do, until `irq_clr_i` is pulsed. A clear pulse makes it 0 on the next cycle.
- R7: After the count reaches N it saturates and no further tick sets `irq_o` again. A restart condition followed by N more idle ticks sets it again.
- R8: While `enable_i` is 0 the count is held at zero and `irq_o` is not set. Dropping the enable in the middle of a count restarts it.
- R9: A limit of 0 disables detection: the count stays at zero and `irq_o` is never set.
- R10: If the N-th tick and `irq_clr_i` fall in the same cycle, setting wins and `irq_o` reads 1 afterwards.
- R11: Only cycles with `tick_i` high advance the count. Any number of idle clock cycles without a tick leaves `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Detector enable |
| limit_i | input | 24 | Idle limit in bit-time ticks; 0 disables |
| tick_i | input | 1 | One-cycle pulse per bit time |
| fifo_nonempty_i | input | 1 | Receive queue holds unread data |
| byte_rcvd_i | input | 1 | One-cycle pulse per byte written into the queue |
| fifo_pop_i | input | 1 | One-cycle pulse per byte read from the queue |
| irq_clr_i | input | 1 | Clears the timeout interrupt |
| irq_o | output | 1 | Sticky timeout interrupt, registered |

## Verification
The bench checks the exact tick on which the interrupt rises. A design with an off-by-one compare would fire one tick early or late, and the bench would see it at N-1 or N. Each restart source is applied partway through a count and is followed by N-1 ticks. A design that only paused the count, instead of zeroing it, would fire too soon. After a timeout is cleared, the bench keeps ticking. A counter that wrapped or kept comparing would raise the interrupt a second time. The bench also places a clear on the same cycle as the expiring tick, where a design that gave the clear priority would lose the event. It covers a zero limit, a limit of one, and long gaps between ticks.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;

  // Per-cycle action applied to the idle counter.
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_CLEAR = 2'd1,
    CNT_STEP  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/rx_idle_timeout_ctrl.sv
module rx_idle_timeout_ctrl
  import rx_idle_timeout_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         enable_i,
  input  logic [W-1:0] limit_i,
  input  logic         tick_i,
  input  logic         fifo_nonempty_i,
  input  logic         byte_rcvd_i,
  input  logic         fifo_pop_i,
  input  logic [W-1:0] cnt_q,
  output cnt_op_e      op_o,
  output logic         fire_o
);

  logic         restart;
  logic         below;
  logic [W:0]   cnt_next;

  always_comb begin
    restart  = !enable_i || (limit_i == '0) || !fifo_nonempty_i
               || byte_rcvd_i || fifo_pop_i;
    below    = (cnt_q < limit_i);
    cnt_next = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};

    if (restart)             op_o = CNT_CLEAR;
    else if (tick_i && below) op_o = CNT_STEP;
    else                     op_o = CNT_HOLD;

    fire_o = !restart && tick_i && below && (cnt_next == {1'b0, limit_i});
  end

endmodule

// File: rtl/rx_idle_timeout_counter.sv
module rx_idle_timeout_counter
  import rx_idle_timeout_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_op_e      op_i,
  output logic [W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_CLEAR: cnt_q <= '0;
        CNT_STEP:  cnt_q <= cnt_q + 1'b1;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/rx_idle_timeout_flag.sv
module rx_idle_timeout_flag (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic clr_i,
  output logic irq_q
);

  // Setting has priority over clearing so no event is lost.
  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (fire_i) irq_q <= 1'b1;
    else if (clr_i)  irq_q <= 1'b0;
  end

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rx_idle_timeout_pkg::*;
#(
  parameter int LIMIT_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               tick_i,
  input  logic               fifo_nonempty_i,
  input  logic               byte_rcvd_i,
  input  logic               fifo_pop_i,
  input  logic               irq_clr_i,
  output logic               irq_o
);

  cnt_op_e            op;
  logic               fire;
  logic [LIMIT_W-1:0] cnt_q;

  rx_idle_timeout_ctrl #(.W(LIMIT_W)) u_ctrl (
    .enable_i        (enable_i),
    .limit_i         (limit_i),
    .tick_i          (tick_i),
    .fifo_nonempty_i (fifo_nonempty_i),
    .byte_rcvd_i     (byte_rcvd_i),
    .fifo_pop_i      (fifo_pop_i),
    .cnt_q           (cnt_q),
    .op_o            (op),
    .fire_o          (fire)
  );

  rx_idle_timeout_counter #(.W(LIMIT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op),
    .cnt_q (cnt_q)
  );

  rx_idle_timeout_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .fire_i (fire),
    .clr_i  (irq_clr_i),
    .irq_q  (irq_o)
  );

endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         enable_i,
  input logic [W-1:0] limit_i,
  input logic         tick_i,
  input logic         fifo_nonempty_i,
  input logic         byte_rcvd_i,
  input logic         fifo_pop_i,
  input logic         irq_clr_i,
  input logic         irq_o,
  input logic [W-1:0] cnt_q,
  input logic         fire
);

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(fifo_nonempty_i && enable_i && tick_i && (limit_i != '0)));

  assert_fire_sets_R2: assert property (@(posedge clk) disable iff (rst)
    fire |=> irq_o);

  assert_empty_clears_R3: assert property (@(posedge clk) disable iff (rst)
    !fifo_nonempty_i |=> (cnt_q == '0));

  assert_byte_clears_R4: assert property (@(posedge clk) disable iff (rst)
    byte_rcvd_i |=> (cnt_q == '0));

  assert_pop_clears_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_pop_i |=> (cnt_q == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && !fire) |=> !irq_o);

  assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == limit_i) && (limit_i != '0) && enable_i && fifo_nonempty_i
     && !byte_rcvd_i && !fifo_pop_i) |=> (cnt_q == $past(cnt_q)));

  assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (cnt_q == '0));

  assert_zero_limit_R9: assert property (@(posedge clk) disable iff (rst)
    (limit_i == '0) |=> (cnt_q == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (fire && irq_clr_i) |=> irq_o);

  assert_no_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && enable_i && fifo_nonempty_i && !byte_rcvd_i && !fifo_pop_i)
      |=> $stable(cnt_q));

endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.W(LIMIT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .enable_i        (enable_i),
  .limit_i         (limit_i),
  .tick_i          (tick_i),
  .fifo_nonempty_i (fifo_nonempty_i),
  .byte_rcvd_i     (byte_rcvd_i),
  .fifo_pop_i      (fifo_pop_i),
  .irq_clr_i       (irq_clr_i),
  .irq_o           (irq_o),
  .cnt_q           (cnt_q),
  .fire            (fire)
);

// File: tb/rx_idle_timeout_test.sv
module rx_idle_timeout_test;

  localparam int CLK_PERIOD = 10;
  localparam int LW         = 24;
  localparam int LIM        = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable_i = 1'b1;
  logic [LW-1:0] limit_i = LW'(LIM);
  logic          tick_i = 1'b0;
  logic          fifo_nonempty_i = 1'b0;
  logic          byte_rcvd_i = 1'b0;
  logic          fifo_pop_i = 1'b0;
  logic          irq_clr_i = 1'b0;
  logic          irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_idle_timeout #(.LIMIT_W(LW)) uut (
    .clk             (clk),
    .rst             (rst),
    .enable_i        (enable_i),
    .limit_i         (limit_i),
    .tick_i          (tick_i),
    .fifo_nonempty_i (fifo_nonempty_i),
    .byte_rcvd_i     (byte_rcvd_i),
    .fifo_pop_i      (fifo_pop_i),
    .irq_clr_i       (irq_clr_i),
    .irq_o           (irq_o)
  );

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (irq_o !== exp) begin
      n_fails++;
      $display("FAIL %s: irq_o actual %b expected %b at %0t", req, irq_o, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_clear();
    irq_clr_i = 1'b1; @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  task automatic drain();
    fifo_nonempty_i = 1'b0; @(negedge clk);
  endtask

  task automatic t_basic_R2();
    drain(); fifo_nonempty_i = 1'b1;
    ticks(LIM - 1); check("R2", 1'b0);
    ticks(1);       check("R2", 1'b1);
    pulse_clear();  check("R6", 1'b0);
    drain(); limit_i = LW'(1); fifo_nonempty_i = 1'b1;
    ticks(1);       check("R2", 1'b1);
    pulse_clear();  limit_i = LW'(LIM);
  endtask

  task automatic t_empty_R3();
    drain(); ticks(2 * LIM); check("R3", 1'b0);
    fifo_nonempty_i = 1'b1; ticks(LIM - 2);
    drain(); fifo_nonempty_i = 1'b1;
    ticks(LIM - 1); check("R3", 1'b0);
    ticks(1);       check("R3", 1'b1);
    pulse_clear();
  endtask

  task automatic t_byte_R4();
    drain(); fifo_nonempty_i = 1'b1;
    ticks(LIM - 1);
    byte_rcvd_i = 1'b1; @(negedge clk); byte_rcvd_i = 1'b0;
    ticks(LIM - 1); check("R4", 1'b0);
    ticks(1);       check("R4", 1'b1);
    pulse_clear();
  endtask

  task automatic t_pop_R5();
    drain(); fifo_nonempty_i = 1'b1;
    ticks(LIM - 1);
    fifo_pop_i = 1'b1; @(negedge clk); fifo_pop_i = 1'b0;
    ticks(LIM - 1); check("R5", 1'b0);
    ticks(1);       check("R5", 1'b1);
    pulse_clear();
  endtask

  task automatic t_sticky_R6();
    drain(); fifo_nonempty_i = 1'b1; ticks(LIM);
    fifo_nonempty_i = 1'b0; ticks(2);
    byte_rcvd_i = 1'b1; @(negedge clk); byte_rcvd_i = 1'b0;
    enable_i = 1'b0; ticks(2);
    check("R6", 1'b1);
    enable_i = 1'b1;
    pulse_clear(); check("R6", 1'b0);
  endtask

  task automatic t_saturate_R7();
    drain(); fifo_nonempty_i = 1'b1; ticks(LIM);
    check("R7", 1'b1);
    pulse_clear();
    ticks(3 * LIM); check("R7", 1'b0);
    fifo_pop_i = 1'b1; @(negedge clk); fifo_pop_i = 1'b0;
    ticks(LIM); check("R7", 1'b1);
    pulse_clear();
  endtask

  task automatic t_enable_R8();
    drain(); enable_i = 1'b0; fifo_nonempty_i = 1'b1;
    ticks(2 * LIM); check("R8", 1'b0);
    enable_i = 1'b1; ticks(LIM - 2);
    enable_i = 1'b0; @(negedge clk); enable_i = 1'b1;
    ticks(LIM - 1); check("R8", 1'b0);
    ticks(1);       check("R8", 1'b1);
    pulse_clear();
  endtask

  task automatic t_zero_R9();
    drain(); limit_i = '0; fifo_nonempty_i = 1'b1;
    ticks(3 * LIM); check("R9", 1'b0);
    limit_i = LW'(LIM);
  endtask

  task automatic t_collide_R10();
    drain(); fifo_nonempty_i = 1'b1; ticks(LIM - 1);
    tick_i = 1'b1; irq_clr_i = 1'b1; @(negedge clk);
    tick_i = 1'b0; irq_clr_i = 1'b0;
    check("R10", 1'b1);
    pulse_clear(); check("R10", 1'b0);
  endtask

  task automatic t_notick_R11();
    drain(); fifo_nonempty_i = 1'b1; ticks(LIM - 1);
    idle(40); check("R11", 1'b0);
    ticks(1); check("R11", 1'b1);
    pulse_clear();
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0);
    t_basic_R2();
    t_empty_R3();
    t_byte_R4();
    t_pop_R5();
    t_sticky_R6();
    t_saturate_R7();
    t_enable_R8();
    t_zero_R9();
    t_collide_R10();
    t_notick_R11();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule